// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the signed multiply-accumulate engine of a 32-bit processor. It keeps a 64-bit accumulator as two 32-bit halves, a high half and a low half. On each accepted operation it multiplies two signed operands and adds the product into the accumulator. The operation can be a long form, which multiplies two full 32-bit operands, or a word form, which multiplies the low 16 bits of each operand.

A saturation-mode input chooses between plain two's-complement wrap-around and clamped arithmetic. Saturation behaves differently in the two forms. In the long form the result is limited to a signed 48-bit range. In the word form only the low half takes part in the sum; on a 32-bit overflow the low half is clamped and the high half is set to one as an overflow marker.

The host can write either half, clear both halves, and read both halves at any time. Operand fetch and address stepping are done outside the block.

Top module: `mac_sat_unit`

## Requirements
- R1: While reset is asserted and after it is released, both accumulator halves read zero and `done` is low.
- R2: With `op_word`=0 and `sat_en`=0, the 64-bit signed product of `opnd_a` and `opnd_b` is added to the 64-bit accumulator {`acc_hi`,`acc_lo`}, and the sum wraps modulo 2^64.
- R3: With `op_word`=0 and `sat_en`=1, if the 64-bit sum does not overflow, the result is clamped to the range -2^47 to 2^47-1.
- R4: With `op_word`=0 and `sat_en`=1, if the 64-bit addition overflows, the result becomes -2^47 when the previous accumulator was negative, and 2^47-1 otherwise.
- R5: With `op_word`=1, only bits 15:0 of each operand are used, as signed 16-bit values. Bits 31:16 have no effect. With `sat_en`=0, the sign-extended 32-bit product is added to the full 64-bit accumulator.
- R6: With `op_word`=1 and `sat_en`=1, if there is no 32-bit overflow, `acc_lo` becomes `acc_lo` plus the product, and `acc_hi` keeps its value. `acc_hi` does not affect the result.
- R7: With `op_word`=1 and `sat_en`=1, on a signed 32-bit overflow `acc_lo` becomes 0x80000000 if it was negative before and 0x7FFFFFFF otherwise, and `acc_hi` becomes 1.
- R8: An operation sampled with `op_valid` high at a rising edge shows up on the outputs after that edge. At the same time `done` is high for exactly one cycle. Without `op_valid`, clear or a write, the accumulator holds its value.
- R9: `clr` high at an edge zeroes both halves. It takes priority over writes and operations, and it suppresses `done`.
- R10: `hi_wr`/`lo_wr` load `hi_wdata`/`lo_wdata` into their half. A half that is not written keeps its value. Any write cancels an operation in the same cycle, with no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_word | input | 1 | 1 selects the 16x16 word form, 0 the 32x32 long form |
| sat_en | input | 1 | Saturation mode enable |
| opnd_a | input | 32 | First signed operand |
| opnd_b | input | 32 | Second signed operand |
| clr | input | 1 | Synchronous clear of both halves |
| hi_wr | input | 1 | Write strobe for the high half |
| hi_wdata | input | 32 | Data for the high half |
| lo_wr | input | 1 | Write strobe for the low half |
| lo_wdata | input | 32 | Data for the low half |
| acc_hi | output | 32 | High accumulator half |
| acc_lo | output | 32 | Low accumulator half |
| done | output | 1 | One-cycle pulse marking a completed operation |

## Verification
The assertions assume that the control inputs (`op_valid`, `clr`, both write strobes and the mode bits) are known at every rising edge after reset. They also assume these inputs stay at zero while reset is held, because several properties look one cycle into the past. The bench drives every input on the falling edge, holds all strobes low during reset, and lowers them again shortly after each edge. This keeps the previous-cycle values seen by the properties well defined. The long-form overflow assertions expect a saturating result to stay inside the 48-bit range. To reach the 64-bit overflow case, the stimulus first loads near-limit accumulator values through the write ports.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic {
        OP_LONG = 1'b0,
        OP_WORD = 1'b1
    } mac_op_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_WRITE = 2'd2,
        ACT_OPER  = 2'd3
    } mac_act_e;

endpackage

// File: rtl/mac_long_path.sv
module mac_long_path #(
    parameter int W    = 32,
    parameter int SATW = 48
) (
    input  logic [2*W-1:0] acc,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic           sat,
    output logic [2*W-1:0] res
);
    localparam int DW = 2 * W;
    localparam logic [DW-1:0] HI_LIM = {{(DW-SATW+1){1'b0}}, {(SATW-1){1'b1}}};
    localparam logic [DW-1:0] LO_LIM = ~HI_LIM;

    logic signed [DW-1:0] ext_a_d;
    logic signed [DW-1:0] ext_b_d;
    logic signed [DW-1:0] prod_d;
    logic        [DW:0]   sum_w_d;
    logic        [DW-1:0] sum_d;
    logic                 ovf_d;
    logic                 over_hi_d;
    logic                 under_lo_d;

    always_comb begin
        ext_a_d    = {{W{op_a[W-1]}}, op_a};
        ext_b_d    = {{W{op_b[W-1]}}, op_b};
        prod_d     = ext_a_d * ext_b_d;
        sum_w_d    = {acc[DW-1], acc} + {prod_d[DW-1], prod_d};
        sum_d      = sum_w_d[DW-1:0];
        ovf_d      = sum_w_d[DW] ^ sum_w_d[DW-1];
        over_hi_d  = $signed(sum_d) > $signed(HI_LIM);
        under_lo_d = $signed(sum_d) < $signed(LO_LIM);
        if (!sat) begin
            res = sum_d;
        end else if (ovf_d) begin
            res = acc[DW-1] ? LO_LIM : HI_LIM;
        end else if (over_hi_d) begin
            res = HI_LIM;
        end else if (under_lo_d) begin
            res = LO_LIM;
        end else begin
            res = sum_d;
        end
    end

endmodule

// File: rtl/mac_word_path.sv
module mac_word_path #(
    parameter int W = 32,
    parameter int H = 16
) (
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    input  logic [H-1:0] op_a,
    input  logic [H-1:0] op_b,
    input  logic         sat,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);
    localparam int DW = 2 * W;
    localparam logic [W-1:0] MAX_W = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_W = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

    logic signed [W-1:0] ext_a_d;
    logic signed [W-1:0] ext_b_d;
    logic signed [W-1:0] prod_d;
    logic        [DW-1:0] wide_d;
    logic        [W:0]    sum_d;
    logic                 ovf_d;

    always_comb begin
        ext_a_d = {{(W-H){op_a[H-1]}}, op_a};
        ext_b_d = {{(W-H){op_b[H-1]}}, op_b};
        prod_d  = ext_a_d * ext_b_d;
        wide_d  = {acc_hi, acc_lo} + {{W{prod_d[W-1]}}, prod_d};
        sum_d   = {acc_lo[W-1], acc_lo} + {prod_d[W-1], prod_d};
        ovf_d   = sum_d[W] ^ sum_d[W-1];
        if (!sat) begin
            res_hi = wide_d[DW-1:W];
            res_lo = wide_d[W-1:0];
        end else if (ovf_d) begin
            res_hi = ONE_W;
            res_lo = acc_lo[W-1] ? MIN_W : MAX_W;
        end else begin
            res_hi = acc_hi;
            res_lo = sum_d[W-1:0];
        end
    end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
    parameter int W    = 32,
    parameter int H    = 16,
    parameter int SATW = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic         op_word,
    input  logic         sat_en,
    input  logic [31:0]  opnd_a,
    input  logic [31:0]  opnd_b,
    input  logic         clr,
    input  logic         hi_wr,
    input  logic [31:0]  hi_wdata,
    input  logic         lo_wr,
    input  logic [31:0]  lo_wdata,
    output logic [31:0]  acc_hi,
    output logic [31:0]  acc_lo,
    output logic         done
);
    import mac_pkg::*;

    localparam int DW = 2 * W;

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic         done;
    } mac_state_t;

    mac_state_t   st_d, st_q;
    mac_act_e     act_d;
    mac_op_e      kind_d;
    logic [DW-1:0] long_res_d;
    logic [W-1:0]  word_hi_d;
    logic [W-1:0]  word_lo_d;

    mac_long_path #(.W(W), .SATW(SATW)) u_long (
        .acc  ({st_q.hi, st_q.lo}),
        .op_a (opnd_a),
        .op_b (opnd_b),
        .sat  (sat_en),
        .res  (long_res_d)
    );

    mac_word_path #(.W(W), .H(H)) u_word (
        .acc_hi (st_q.hi),
        .acc_lo (st_q.lo),
        .op_a   (opnd_a[H-1:0]),
        .op_b   (opnd_b[H-1:0]),
        .sat    (sat_en),
        .res_hi (word_hi_d),
        .res_lo (word_lo_d)
    );

    always_comb begin
        kind_d = op_word ? OP_WORD : OP_LONG;
        if (clr)                 act_d = ACT_CLEAR;
        else if (hi_wr || lo_wr) act_d = ACT_WRITE;
        else if (op_valid)       act_d = ACT_OPER;
        else                     act_d = ACT_HOLD;

        st_d      = st_q;
        st_d.done = 1'b0;
        case (act_d)
            ACT_CLEAR: begin
                st_d.hi = '0;
                st_d.lo = '0;
            end
            ACT_WRITE: begin
                if (hi_wr) st_d.hi = hi_wdata;
                if (lo_wr) st_d.lo = lo_wdata;
            end
            ACT_OPER: begin
                st_d.done = 1'b1;
                if (kind_d == OP_WORD) begin
                    st_d.hi = word_hi_d;
                    st_d.lo = word_lo_d;
                end else begin
                    st_d.hi = long_res_d[DW-1:W];
                    st_d.lo = long_res_d[W-1:0];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_hi = st_q.hi;
    assign acc_lo = st_q.lo;
    assign done   = st_q.done;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(op_valid) && !$past(clr) && !$past(hi_wr) && !$past(lo_wr));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!op_valid && !clr && !hi_wr && !lo_wr) |-> $stable(acc_hi) && $stable(acc_lo) && !done);

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (acc_hi == '0) && (acc_lo == '0) && !done);

    // R10
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hi_wr && !clr) |-> acc_hi == $past(hi_wdata));

    // R3
    long_sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(!op_word && sat_en)) |->
            (acc_hi[W-1:SATW-W-1] == '0) || (acc_hi[W-1:SATW-W-1] == '1));

    // R7
    word_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(op_word && sat_en) && (acc_hi != $past(acc_hi))) |-> acc_hi == 32'd1);

endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam longint MAX48 = 64'sh0000_7FFF_FFFF_FFFF;
    localparam longint MIN48 = -64'sh0000_8000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_word = 1'b0, sat_en = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        clr = 1'b0, hi_wr = 1'b0, lo_wr = 1'b0;
    logic [31:0] hi_wdata = '0, lo_wdata = '0;
    logic [31:0] acc_hi, acc_lo;
    logic        done;

    int     checks = 0;
    int     fails  = 0;
    longint m_acc  = 0;
    logic   m_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_sat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .sat_en(sat_en), .opnd_a(opnd_a), .opnd_b(opnd_b), .clr(clr),
        .hi_wr(hi_wr), .hi_wdata(hi_wdata), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
    );

    task automatic compare(input string tag);
        checks++;
        if ({acc_hi, acc_lo} !== m_acc || done !== m_done) begin
            fails++;
            $display("FAIL %s: acc=%h done=%b expected acc=%h done=%b",
                     tag, {acc_hi, acc_lo}, done, m_acc, m_done);
        end
    endtask

    task automatic model_update();
        longint mul;
        logic signed [65:0] wide;
        longint lo_s, sum32;
        int     p32;
        m_done = 1'b0;
        if (clr) begin
            m_acc = 0;
        end else if (hi_wr || lo_wr) begin
            if (hi_wr) m_acc[63:32] = hi_wdata;
            if (lo_wr) m_acc[31:0]  = lo_wdata;
        end else if (op_valid) begin
            m_done = 1'b1;
            if (!op_word) begin
                mul = longint'(int'(opnd_a)) * longint'(int'(opnd_b));
                if (!sat_en) begin
                    m_acc = m_acc + mul;
                end else begin
                    wide = m_acc;
                    wide = wide + mul;
                    if (wide > MAX48)      m_acc = MAX48;
                    else if (wide < MIN48) m_acc = MIN48;
                    else                   m_acc = longint'(wide);
                end
            end else begin
                p32 = int'(shortint'(opnd_a[15:0])) * int'(shortint'(opnd_b[15:0]));
                if (!sat_en) begin
                    m_acc = m_acc + longint'(p32);
                end else begin
                    lo_s  = longint'(int'(m_acc[31:0]));
                    sum32 = lo_s + longint'(p32);
                    if (sum32 > 64'sd2147483647) begin
                        m_acc = {32'd1, 32'h7FFF_FFFF};
                    end else if (sum32 < -64'sd2147483648) begin
                        m_acc = {32'd1, 32'h8000_0000};
                    end else begin
                        m_acc[31:0] = sum32[31:0];
                    end
                end
            end
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        #1;
        op_valid = 1'b0; clr = 1'b0; hi_wr = 1'b0; lo_wr = 1'b0;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_op(input logic w, input logic s, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        op_valid = 1'b1; op_word = w; sat_en = s; opnd_a = a; opnd_b = b;
        step(tag);
    endtask

    task automatic do_wr(input logic hw, input logic [31:0] hv,
                         input logic lw, input logic [31:0] lv, input string tag);
        hi_wr = hw; hi_wdata = hv; lo_wr = lw; lo_wdata = lv;
        step(tag);
    endtask

    task automatic do_clr(input string tag);
        clr = 1'b1;
        step(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        // R2: long form, wrap-around
        do_op(1'b0, 1'b0, 32'd5, 32'hFFFF_FFFD, "R2 small product");
        do_op(1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R2 large product");
        do_wr(1'b1, 32'h7FFF_FFFF, 1'b1, 32'hFFFF_FFFF, "R10 load both halves");
        do_op(1'b0, 1'b0, 32'd1, 32'd1, "R2 wrap past 2^63");

        // R8: idle holds
        step("R8 idle hold");
        step("R8 idle hold again");

        // R3: clamp within 64-bit range
        do_wr(1'b1, 32'h0000_7FFF, 1'b1, 32'hFFFF_FF00, "R10 near max48");
        do_op(1'b0, 1'b1, 32'h1000, 32'h1000, "R3 clamp to max48");
        do_clr("R9 clear");
        do_op(1'b0, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, "R3 clamp to min48");
        do_op(1'b0, 1'b1, 32'd7, 32'd9, "R3 inside range after clamp");

        // R4: 64-bit overflow with saturation
        do_wr(1'b1, 32'h7FFF_FFFF, 1'b1, 32'hFFFF_FFFF, "R10 near 2^63");
        do_op(1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R4 positive overflow");
        do_wr(1'b1, 32'h8000_0000, 1'b1, 32'h0, "R10 at -2^63");
        do_op(1'b0, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, "R4 negative overflow");

        // R5: word form, no saturation, upper operand bits ignored
        do_clr("R9 clear");
        do_op(1'b1, 1'b0, 32'hABCD_FFFE, 32'h1234_0003, "R5 negative product sign-extends");
        do_op(1'b1, 1'b0, 32'hFFFF_7FFF, 32'h0000_7FFF, "R5 positive product");

        // R6: word saturation, no overflow, high half untouched
        do_wr(1'b1, 32'h1234_5678, 1'b1, 32'd100, "R10 preload");
        do_op(1'b1, 1'b1, 32'h0000_FFFF, 32'd50, "R6 high half kept");

        // R7: word saturation overflow
        do_wr(1'b1, 32'h55, 1'b1, 32'h7FFF_FF00, "R10 preload");
        do_op(1'b1, 1'b1, 32'h7FFF, 32'h7FFF, "R7 positive overflow");
        do_wr(1'b1, 32'h55, 1'b1, 32'h8000_0010, "R10 preload");
        do_op(1'b1, 1'b1, 32'h8000, 32'h7FFF, "R7 negative overflow");

        // R9: clear wins over an operation and writes
        op_valid = 1'b1; op_word = 1'b0; sat_en = 1'b0; opnd_a = 32'd3; opnd_b = 32'd3;
        hi_wr = 1'b1; hi_wdata = 32'hDEAD_BEEF;
        do_clr("R9 clear over op and write");

        // R10: write cancels op, other half keeps value
        do_wr(1'b0, 32'h0, 1'b1, 32'd40, "R10 low write");
        op_valid = 1'b1; op_word = 1'b1; sat_en = 1'b1; opnd_a = 32'd2; opnd_b = 32'd2;
        do_wr(1'b1, 32'hCAFE_0001, 1'b0, 32'h0, "R10 high write cancels op");

        // mixed stimulus, compared every cycle
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = int'($urandom_range(0, 19));
            if (sel == 0) begin
                do_clr("R9 random clear");
            end else if (sel < 3) begin
                do_wr($urandom_range(0, 1) == 1, $urandom, $urandom_range(0, 1) == 1,
                      $urandom, "R10 random write");
            end else if (sel < 5) begin
                step("R8 random idle");
            end else begin
                logic w, s;
                w = $urandom_range(0, 1) == 1;
                s = $urandom_range(0, 1) == 1;
                do_op(w, s, $urandom, $urandom,
                      w ? (s ? "R7 random word sat" : "R5 random word")
                        : (s ? "R3 random long sat" : "R2 random long"));
            end
        end

        finish_run();
    end

endmodule